// File: doc/BRIEF.md
# SPI Master Controller with Transmit and Receive Queues

This block is a memory-mapped SPI master. Software talks to it over a simple register bus: an address, write data, a write strobe and a read strobe, with read data returned one cycle after the read strobe. Words written to the transmit-data address enter a 32-entry transmit queue. Each received frame lands in a 32-entry receive queue, which is drained through the receive-data address.

Software first clears the enable register. It then programs clock polarity, clock phase, frame size (8 or 16 bits), the SCLK divider and the burst length. The burst length is written as the frame count minus one. Setting enable starts a full-duplex burst. Each frame takes one word from the transmit queue, shifts it out most significant bit first on MOSI, and captures the same number of bits from MISO into the receive queue.

The chip-select lines are active low and come from a one-hot select register that works apart from the shift engine and the enable bit. The status register shows whether a burst is in progress, whether the transmit queue is full and whether the receive queue is empty.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, SCLK and MOSI are 0, all chip-select lines are high, and the status register (address 5) reads busy=0 (bit 0), tx_full=0 (bit 1) and rx_empty=1 (bit 2).
- R2: A write to the select register (address 4) drives chip-select line n low when bit n is set. The write is accepted whether enable is set or clear. Writing 0 releases every line. A write with more than one bit set in the low CS_N bits is ignored.
- R3: The control (address 0), frame-count (address 1) and divider (address 2) registers read back their contents. A write to any of them while enable (address 3, bit 0) is 1 is ignored. The frame-count register holds all 16 bits, up to 0xFFFF.
- R4: Writing 1 to enable while it is 0 starts a burst of exactly frame-count+1 frames. Busy (status bit 0) stays 1 until the final SCLK edge of the last frame, then drops. Clearing enable aborts a burst.
- R5: Control bit 0 (polarity) sets the SCLK idle level, which SCLK shows whenever no burst runs. Control bit 1 (phase) selects the data edges. With phase 0, MISO is sampled on the first edge of each bit. With phase 1, it is sampled on the second edge. MOSI changes only on the other edge of each bit.
- R6: Control bit 2 selects 16-bit frames when 1 and 8-bit frames when 0. Bits go out most significant bit first. An 8-bit frame sends bits 7..0 of the queued word.
- R7: Every frame pushes exactly one word into the receive queue, in frame order. An 8-bit frame is stored in bits 7..0 with the upper bits zero. Reads at address 7 pop the receive queue, and rx_empty is set once every received word has been read.
- R8: Each SCLK half-period lasts max(D/2,1) clock cycles, where D is the divider value and D/2 is rounded down. A divider of 0 holds SCLK at its idle level and the burst makes no progress.
- R9: When the transmit queue is empty at the start of a frame, SCLK stops and busy stays 1 until a word is written to address 6. The burst then continues with no frame lost.
- R10: Both queues hold 32 words. tx_full (status bit 1) is set when 32 words are queued, and a write to a full transmit queue is dropped. A read of address 7 while the receive queue is empty returns 0.

Verification below leans on how a fault surfaces at the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, valid the cycle after bus_re |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | CS_N | Active-low chip selects |

## Verification
A wrong bit counter or phase decode shows up within one frame. MOSI would carry a misordered or shifted word, and the word read back from the receive queue would not match what the slave model sent. A wrong frame counter shows in the number of frames the slave model counts before busy falls, or in a receive queue holding too few or too many words. A divider fault shows in the first measured SCLK half-period. A queue pointer fault shows as a dropped word, a repeated word or a wrong flag once the queue fills or underruns.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_FRAMES = 3'd1;
  localparam logic [2:0] A_DIV    = 3'd2;
  localparam logic [2:0] A_EN     = 3'd3;
  localparam logic [2:0] A_SEL    = 3'd4;
  localparam logic [2:0] A_STAT   = 3'd5;
  localparam logic [2:0] A_TX     = 3'd6;
  localparam logic [2:0] A_RX     = 3'd7;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT} eng_state_e;

  typedef struct packed {
    logic wide;
    logic cpha;
    logic cpol;
  } spi_ctrl_t;
endpackage

// File: rtl/spi_sync_fifo.sv
module spi_sync_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_q, wr_d, rd_q, rd_d;
  logic         do_push, do_pop;

  assign full    = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign empty   = (wr_q == rd_q);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_q[AW-1:0]];

  always_comb begin
    wr_d = do_push ? wr_q + {{AW{1'b0}}, 1'b1} : wr_q;
    rd_d = do_pop  ? rd_q + {{AW{1'b0}}, 1'b1} : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q[AW-1:0]] <= push_data;
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_fifo_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          wide,
  input  logic [CW-1:0] div,
  input  logic [FW-1:0] frames_m1,
  input  logic          tx_empty,
  input  logic [DW-1:0] tx_data,
  output logic          tx_pop,
  input  logic          rx_full,
  output logic          rx_push,
  output logic [DW-1:0] rx_word,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso,
  output logic          busy
);
  localparam int unsigned EW = $clog2(2 * DW);
  localparam logic [FW:0] ONE_F = {{FW{1'b0}}, 1'b1};

  eng_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d, half;
  logic [EW-1:0] ecnt_q, ecnt_d, last_e;
  logic [FW:0]   left_q, left_d;
  logic [DW-1:0] tx_sh_q, tx_sh_d, rx_sh_q, rx_sh_d, ld_word;
  logic          sclk_q, sclk_d, mosi_q, mosi_d, en_prev_q;
  logic          tick, lead, last_hit, launch, sample;

  assign half     = (div[CW-1:1] == '0) ? CW'(1) : CW'(div[CW-1:1]);
  assign tick     = (div != '0) && (cnt_q == half - CW'(1));
  assign last_e   = wide ? EW'(2 * DW - 1) : EW'(DW - 1);
  assign last_hit = (ecnt_q == last_e);
  assign lead     = ~ecnt_q[0];
  assign ld_word  = wide ? tx_data : (tx_data << (DW / 2));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ecnt_d  = ecnt_q;
    left_d  = left_q;
    tx_sh_d = tx_sh_q;
    rx_sh_d = rx_sh_q;
    sclk_d  = sclk_q;
    mosi_d  = mosi_q;
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    launch  = 1'b0;
    sample  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        sclk_d = cpol;
        if (enable && !en_prev_q) begin
          left_d  = {1'b0, frames_m1} + ONE_F;
          state_d = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (!tx_empty && !rx_full) begin
          tx_pop = 1'b1;
          cnt_d  = '0;
          ecnt_d = '0;
          if (!cpha) begin
            mosi_d  = ld_word[DW-1];
            tx_sh_d = ld_word << 1;
          end else begin
            tx_sh_d = ld_word;
          end
          state_d = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (div != '0) begin
          if (tick) begin
            cnt_d  = '0;
            sclk_d = ~sclk_q;
            launch = cpha ? lead : (!lead && !last_hit);
            sample = cpha ? !lead : lead;
            if (launch) begin
              mosi_d  = tx_sh_q[DW-1];
              tx_sh_d = tx_sh_q << 1;
            end
            if (sample) rx_sh_d = {rx_sh_q[DW-2:0], miso};
            if (last_hit) begin
              rx_push = 1'b1;
              left_d  = left_q - ONE_F;
              state_d = (left_q == ONE_F) ? ST_IDLE : ST_LOAD;
            end else begin
              ecnt_d = ecnt_q + EW'(1);
            end
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (!enable) begin
      state_d = ST_IDLE;
      sclk_d  = cpol;
    end
  end

  assign rx_word = wide ? rx_sh_d : {{(DW / 2){1'b0}}, rx_sh_d[DW/2-1:0]};
  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
  assign busy    = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      ecnt_q    <= '0;
      left_q    <= '0;
      tx_sh_q   <= '0;
      rx_sh_q   <= '0;
      sclk_q    <= 1'b0;
      mosi_q    <= 1'b0;
      en_prev_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      ecnt_q    <= ecnt_d;
      left_q    <= left_d;
      tx_sh_q   <= tx_sh_d;
      rx_sh_q   <= rx_sh_d;
      sclk_q    <= sclk_d;
      mosi_q    <= mosi_d;
      en_prev_q <= enable;
    end
  end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned CS_N       = 4,
  parameter int unsigned DIV_W      = 16,
  parameter int unsigned FRAME_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [CS_N-1:0]   cs_n
);
  logic [1:0]         rs_q;
  logic               rst_sn;
  spi_ctrl_t          ctrl_q, ctrl_d;
  logic [FRAME_W-1:0] frames_q, frames_d;
  logic [DIV_W-1:0]   div_q, div_d;
  logic               en_q, en_d;
  logic [CS_N-1:0]    sel_q, sel_d, sel_wr;
  logic [DATA_W-1:0]  rdata_q, rdata_d;
  logic               cfg_wr, tx_push, rx_pop, busy;
  logic               tx_full, tx_empty, tx_pop, rx_full, rx_empty, rx_push;
  logic [DATA_W-1:0]  tx_head, rx_head, rx_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  assign cfg_wr  = bus_we && !en_q;
  assign sel_wr  = bus_wdata[CS_N-1:0];
  assign tx_push = bus_we && (bus_addr == A_TX);
  assign rx_pop  = bus_re && (bus_addr == A_RX);

  always_comb begin
    ctrl_d   = (cfg_wr && bus_addr == A_CTRL)   ? spi_ctrl_t'(bus_wdata[2:0]) : ctrl_q;
    frames_d = (cfg_wr && bus_addr == A_FRAMES) ? bus_wdata[FRAME_W-1:0]      : frames_q;
    div_d    = (cfg_wr && bus_addr == A_DIV)    ? bus_wdata[DIV_W-1:0]        : div_q;
    en_d     = (bus_we && bus_addr == A_EN)     ? bus_wdata[0]                : en_q;
    sel_d    = sel_q;
    if (bus_we && bus_addr == A_SEL && ((sel_wr & (sel_wr - CS_N'(1))) == '0))
      sel_d = sel_wr;
  end

  always_comb begin
    unique case (bus_addr)
      A_CTRL:   rdata_d = DATA_W'(ctrl_q);
      A_FRAMES: rdata_d = DATA_W'(frames_q);
      A_DIV:    rdata_d = DATA_W'(div_q);
      A_EN:     rdata_d = DATA_W'(en_q);
      A_SEL:    rdata_d = DATA_W'(sel_q);
      A_STAT:   rdata_d = DATA_W'({rx_empty, tx_full, busy});
      A_RX:     rdata_d = rx_empty ? '0 : rx_head;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ctrl_q   <= '0;
      frames_q <= '0;
      div_q    <= '0;
      en_q     <= 1'b0;
      sel_q    <= '0;
      rdata_q  <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      frames_q <= frames_d;
      div_q    <= div_d;
      en_q     <= en_d;
      sel_q    <= sel_d;
      if (bus_re) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign cs_n      = ~sel_q;

  spi_sync_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_sn), .push(tx_push), .push_data(bus_wdata),
    .pop(tx_pop), .head(tx_head), .full(tx_full), .empty(tx_empty)
  );

  spi_sync_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_sn), .push(rx_push), .push_data(rx_word),
    .pop(rx_pop), .head(rx_head), .full(rx_full), .empty(rx_empty)
  );

  spi_shift_engine #(.DW(DATA_W), .CW(DIV_W), .FW(FRAME_W)) u_eng (
    .clk(clk), .rst_n(rst_sn), .enable(en_q),
    .cpol(ctrl_q.cpol), .cpha(ctrl_q.cpha), .wide(ctrl_q.wide),
    .div(div_q), .frames_m1(frames_q),
    .tx_empty(tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
    .rx_full(rx_full), .rx_push(rx_push), .rx_word(rx_word),
    .sclk(sclk), .mosi(mosi), .miso(miso), .busy(busy)
  );
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
  parameter int unsigned CS_N    = 4,
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned FRAME_W = 16
) (
  input logic               clk,
  input logic               rst_sn,
  input logic               en_q,
  input logic [2:0]         ctrl,
  input logic [FRAME_W-1:0] frames,
  input logic [DIV_W-1:0]   div,
  input logic               busy,
  input logic               sclk,
  input logic [CS_N-1:0]    cs_n,
  input logic               tx_pop,
  input logic               tx_empty,
  input logic               rx_push,
  input logic               rx_full
);
  p_cs_onehot_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0(~cs_n));

  p_cfg_locked_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (en_q && $past(en_q)) |-> ($stable(ctrl) && $stable(frames) && $stable(div)));

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(busy) |-> (sclk == ctrl[0]));

  p_div0_hold_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy && $past(busy) && div == '0) |-> $stable(sclk));

  p_no_underrun_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    tx_pop |-> !tx_empty);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    rx_push |-> !rx_full);
endmodule

bind spi_fifo_master spi_fifo_master_chk #(
  .CS_N(CS_N), .DIV_W(DIV_W), .FRAME_W(FRAME_W)
) u_chk (
  .clk(clk), .rst_sn(rst_sn), .en_q(en_q), .ctrl(ctrl_q), .frames(frames_q),
  .div(div_q), .busy(busy), .sclk(sclk), .cs_n(cs_n), .tx_pop(tx_pop),
  .tx_empty(tx_empty), .rx_push(rx_push), .rx_full(rx_full)
);

// File: tb/spi_fifo_master_test.sv
module spi_fifo_master_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_CTRL = 3'd0, A_FRAMES = 3'd1, A_DIV = 3'd2, A_EN = 3'd3,
                         A_SEL = 3'd4, A_STAT = 3'd5, A_TX = 3'd6, A_RX = 3'd7;

  logic        clk, rst_n, bus_we, bus_re, miso, sclk, mosi;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [3:0]  cs_n;

  int vectors = 0, misses = 0, cyc = 0;
  logic [15:0] tx_words [32];
  logic [15:0] slv_words [32];
  logic [15:0] mosi_seen [32];
  int sf, s_ecnt, exp_half, int_bad, int_seen, last_cyc;
  logic [15:0] s_sh, s_mosi;
  logic cur_pha, cur_wide, sclk_prev;

  spi_fifo_master uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] mask_w(input logic [15:0] w, input logic wd);
    return wd ? w : {8'h00, w[7:0]};
  endfunction
  function automatic logic [15:0] align_w(input logic [15:0] w, input logic wd);
    return wd ? w : {w[7:0], 8'h00};
  endfunction
  function automatic int half_of(input int d);
    return (d / 2 < 1) ? 1 : d / 2;
  endfunction

  task automatic chk_eq(input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic slave_reset();
    sf = 0; s_ecnt = 0; s_mosi = '0;
    s_sh = align_w(slv_words[0], cur_wide);
    if (!cur_pha) begin miso = s_sh[15]; s_sh = s_sh << 1; end
  endtask

  task automatic slave_loop();
    forever begin
      @(negedge clk);
      if (sclk !== sclk_prev) begin
        logic lead, launch, sample;
        int last;
        last   = cur_wide ? 31 : 15;
        lead   = (s_ecnt % 2) == 0;
        launch = cur_pha ? lead : (!lead && s_ecnt != last);
        sample = cur_pha ? !lead : lead;
        if (s_ecnt != 0) begin
          int_seen++;
          if (cyc - last_cyc != exp_half) int_bad++;
        end
        last_cyc = cyc;
        if (sample) s_mosi = {s_mosi[14:0], mosi};
        if (launch) begin miso = s_sh[15]; s_sh = s_sh << 1; end
        if (s_ecnt == last) begin
          if (sf < 32) mosi_seen[sf] = mask_w(s_mosi, cur_wide);
          sf++;
          s_ecnt = 0;
          s_sh = (sf < 32) ? align_w(slv_words[sf], cur_wide) : 16'h0;
          if (!cur_pha) begin miso = s_sh[15]; s_sh = s_sh << 1; end
        end else begin
          s_ecnt++;
        end
      end
      sclk_prev = sclk;
    end
  endtask

  task automatic wait_idle(input string tag);
    logic [15:0] st;
    bit done = 0;
    for (int k = 0; k < 20000 && !done; k++) begin
      bus_read(A_STAT, st);
      if (st[0] == 1'b0) done = 1;
    end
    chk_eq({tag, " R4 busy falls"}, 32'(done), 32'd1);
  endtask

  task automatic prep(input bit pol, input bit pha, input bit wd, input int dv, input int n);
    bus_write(A_EN, 16'h0);
    bus_write(A_CTRL, {13'd0, wd, pha, pol});
    bus_write(A_FRAMES, 16'(n - 1));
    bus_write(A_DIV, 16'(dv));
    for (int i = 0; i < n; i++) begin
      tx_words[i]  = 16'($urandom);
      slv_words[i] = 16'($urandom);
    end
    cur_pha = pha; cur_wide = wd; exp_half = half_of(dv);
    int_bad = 0; int_seen = 0;
  endtask

  task automatic check_results(input string tag, input bit pol, input bit wd, input int n);
    logic [15:0] got;
    chk_eq({tag, " R4 frame count"}, 32'(sf), 32'(n));
    chk_eq({tag, " R5 sclk idle level"}, 32'(sclk), 32'(pol));
    chk_eq({tag, " R8 half-period errors"}, 32'(int_bad), 32'd0);
    chk_eq({tag, " R8 edges measured"}, 32'(int_seen > 0), 32'd1);
    for (int i = 0; i < n; i++)
      chk_eq({tag, " R6 mosi frame"}, 32'(mosi_seen[i]), 32'(mask_w(tx_words[i], wd)));
    for (int i = 0; i < n; i++) begin
      bus_read(A_RX, got);
      chk_eq({tag, " R7 rx word"}, 32'(got), 32'(mask_w(slv_words[i], wd)));
    end
    bus_read(A_STAT, got);
    chk_eq({tag, " R7 rx empty after drain"}, 32'(got[2]), 32'd1);
  endtask

  task automatic run_burst(input bit pol, input bit pha, input bit wd, input int dv,
                           input int n, input int pre, input string tag);
    logic [15:0] got;
    logic snap;
    prep(pol, pha, wd, dv, n);
    for (int i = 0; i < pre; i++) bus_write(A_TX, tx_words[i]);
    slave_reset();
    bus_write(A_EN, 16'h1);
    if (pre < n) begin
      repeat (300) @(negedge clk);
      bus_read(A_STAT, got);
      chk_eq({tag, " R9 busy while starved"}, 32'(got[0]), 32'd1);
      snap = sclk;
      repeat (60) @(negedge clk);
      chk_eq({tag, " R9 sclk held while starved"}, 32'(sclk), 32'(snap));
      chk_eq({tag, " R9 frames before stall"}, 32'(sf), 32'(pre));
      for (int i = pre; i < n; i++) bus_write(A_TX, tx_words[i]);
    end
    wait_idle(tag);
    check_results(tag, pol, wd, n);
  endtask

  initial begin
    logic [15:0] got;
    repeat (190000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [15:0] got;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_we = 1'b0; bus_re = 1'b0; bus_addr = '0; bus_wdata = '0;
    miso = 1'b0; sclk_prev = 1'b0; cur_pha = 0; cur_wide = 0; exp_half = 1;
    sf = 0; s_ecnt = 0; int_bad = 0; int_seen = 0; last_cyc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    fork slave_loop(); join_none

    // R1 reset state
    chk_eq("R1 sclk", 32'(sclk), 32'd0);
    chk_eq("R1 mosi", 32'(mosi), 32'd0);
    chk_eq("R1 cs_n", 32'(cs_n), 32'hF);
    bus_read(A_STAT, got);
    chk_eq("R1 status", 32'(got), 32'h4);

    // R2 chip selects
    bus_write(A_SEL, 16'h0004);
    chk_eq("R2 select line 2", 32'(cs_n), 32'hB);
    bus_write(A_EN, 16'h1);
    bus_write(A_SEL, 16'h0001);
    chk_eq("R2 select with enable set", 32'(cs_n), 32'hE);
    bus_write(A_SEL, 16'h0006);
    chk_eq("R2 multi-bit write ignored", 32'(cs_n), 32'hE);
    bus_write(A_SEL, 16'h0000);
    chk_eq("R2 release all", 32'(cs_n), 32'hF);
    bus_write(A_EN, 16'h0);

    // R3 configuration lock
    bus_write(A_CTRL, 16'h0005);
    bus_write(A_FRAMES, 16'h0010);
    bus_write(A_DIV, 16'h0006);
    bus_write(A_EN, 16'h1);
    bus_write(A_CTRL, 16'h0002);
    bus_write(A_FRAMES, 16'h1234);
    bus_write(A_DIV, 16'h0009);
    bus_read(A_CTRL, got);   chk_eq("R3 ctrl locked", 32'(got), 32'h5);
    bus_read(A_FRAMES, got); chk_eq("R3 frames locked", 32'(got), 32'h10);
    bus_read(A_DIV, got);    chk_eq("R3 div locked", 32'(got), 32'h6);
    bus_write(A_EN, 16'h0);
    bus_write(A_FRAMES, 16'hFFFF);
    bus_read(A_FRAMES, got); chk_eq("R3 frames max", 32'(got), 32'hFFFF);

    // R5 R6 all modes, both sizes
    for (int m = 0; m < 4; m++) begin
      run_burst(m[0], m[1], 1'b0, 4, 3, 3, "dir8");
      run_burst(m[0], m[1], 1'b1, 4, 3, 3, "dir16");
    end
    run_burst(1'b0, 1'b0, 1'b1, 1, 2, 2, "div1");

    // constrained random bursts
    for (int k = 0; k < 8; k++) begin
      int n;
      n = 1 + int'($urandom % 12);
      run_burst(1'($urandom), 1'($urandom), 1'($urandom), 1 + int'($urandom % 6),
                n, n, "rand");
    end

    // R9 underrun
    run_burst(1'b1, 1'b0, 1'b1, 2, 4, 2, "starve");

    // R8 divider zero
    prep(1'b1, 1'b0, 1'b0, 0, 1);
    bus_write(A_TX, tx_words[0]);
    slave_reset();
    bus_write(A_EN, 16'h1);
    repeat (100) @(negedge clk);
    chk_eq("R8 div0 sclk idle", 32'(sclk), 32'd1);
    chk_eq("R8 div0 no frame", 32'(sf), 32'd0);
    bus_read(A_STAT, got);
    chk_eq("R8 div0 busy", 32'(got[0]), 32'd1);
    bus_write(A_EN, 16'h0);
    bus_read(A_STAT, got);
    chk_eq("R4 abort clears busy", 32'(got[0]), 32'd0);

    // R10 queue depth
    prep(1'b0, 1'b1, 1'b1, 2, 32);
    for (int i = 0; i < 32; i++) bus_write(A_TX, tx_words[i]);
    bus_read(A_STAT, got);
    chk_eq("R10 tx full", 32'(got[1]), 32'd1);
    bus_write(A_TX, 16'hDEAD);
    slave_reset();
    bus_write(A_EN, 16'h1);
    wait_idle("full");
    check_results("full R10", 1'b0, 1'b1, 32);
    bus_read(A_RX, got);
    chk_eq("R10 empty rx read", 32'(got), 32'h0);
    bus_write(A_EN, 16'h0);
    bus_write(A_FRAMES, 16'h0);
    bus_write(A_EN, 16'h1);
    repeat (100) @(negedge clk);
    bus_read(A_STAT, got);
    chk_eq("R10 dropped word not queued", 32'(got[0]), 32'd1);
    bus_write(A_EN, 16'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule